// File: doc/BRIEF.md
# Serial Control Word Register Bank

This block takes configuration words from a host over three slow wires (a latch line, a shift clock and a data line) and turns them into the static control settings of an audio interpolation datapath. Each word is sixteen bits long. Two of its bits pick one of four mode registers. The rest of the word fills that register's fields. The settings come out on plain control pins: the applied left and right attenuation codes, mute, de-emphasis enable and rate, input format and length, output length, word-clock polarity, roll-off select and clock-output halving.

All three wires are asynchronous to the system clock. They pass through synchroniser stages and edge detectors before any state changes. The shift clock and the latch line are therefore sampled, not used as clocks. Attenuation uses a two-step scheme. Writing an attenuation register always stores the code. The level the datapath uses (the applied level) changes only when the word carries its load bit. A common-attenuation setting lets the left code drive both channels.

There is no streaming data path, so the block has no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `sctl_regfile`

## Requirements
- R1: After reset the outputs are: both applied attenuation codes 0xFF, mute off, de-emphasis off, de-emphasis rate code 00, I2S select 0, input length code 00, output length code 00, left_high 1, slow roll-off 0, clock halving 0, and common attenuation off.
- R2: A word is shifted in MSB (B15) first, one bit per rising edge of the shift clock. It is committed on the rising edge of the latch line. Bits B10:B9 select the register: 00 left attenuation, 01 right attenuation, 10 format/mute register, 11 clocking/filter register.
- R3: A latch rising edge that follows a number of shift-clock rising edges other than sixteen changes nothing. Each latch rising edge restarts the bit count, so the next sixteen-bit word is accepted.
- R4: In the format/mute register, B6:B5 drive out_len, B4:B3 drive in_len and B1 drives deemph_en. B0 is an active-low mute bit: B0 = 0 sets mute_on to 1.
- R5: In the clocking/filter register, B6:B5 drive deemph_rate, B4 drives clkout_half and B3 drives slow_rolloff. B2 sets common attenuation. B1 is word-clock polarity: B1 = 0 makes left_high 1. B0 drives in_i2s.
- R6: A left attenuation word (code in B7:B0, load bit B8) or a right attenuation word (same layout) with B8 = 0 stores the code and leaves both applied codes unchanged.
- R7: A left or right attenuation word with B8 = 1 sets the applied left code to the stored left code. It sets the applied right code to the stored left code when common attenuation is on, and to the stored right code otherwise. Both stored codes include the word being written.
- R8: A change of the common-attenuation bit does not alter the applied codes until the next word that carries a load bit.
- R9: Reserved bits (B15:B11 in every register, B8 and B7 and B2 in the format/mute register) have no effect on any output.
- R10: With the default of two synchroniser stages, a committed word is visible on the outputs by the fifth rising edge of the system clock after the latch line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cp_latch | input | 1 | Control port latch line; rising edge commits a word |
| cp_clk | input | 1 | Control port shift clock |
| cp_data | input | 1 | Control port serial data |
| att_left | output | 8 | Applied left attenuation code |
| att_right | output | 8 | Applied right attenuation code |
| mute_on | output | 1 | Soft mute requested |
| deemph_en | output | 1 | De-emphasis enabled |
| deemph_rate | output | 2 | De-emphasis sample-rate code |
| in_i2s | output | 1 | Input uses the I2S framing |
| in_len | output | 2 | Input format/length code |
| out_len | output | 2 | Output word-length code |
| left_high | output | 1 | Left channel when word clock is high |
| slow_rolloff | output | 1 | Slow filter roll-off selected |
| clkout_half | output | 1 | Clock output at half the system clock |

## Verification
A wrong bit count or shift order shows up right away: the word lands in the wrong register or in the wrong field, and a wrong value appears on the pins within five system clocks of the latch edge. A word that should have been rejected would also change a pin in that window. A mistake in the load and common-attenuation logic can stay hidden for a long time. The applied codes only move when a load bit arrives, so the stimulus interleaves store-only writes, polarity changes of the common bit and later loads. It checks the applied codes after each of these writes.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int WORD_BITS = 16;
  localparam int ATT_W     = 8;
  localparam int CNT_W     = $clog2(WORD_BITS + 2);

  localparam int ADDR_HI   = 10;
  localparam int ADDR_LO   = 9;
  localparam int LOAD_BIT  = 8;

  typedef enum logic [1:0] {
    REG_ATT_L = 2'b00,
    REG_ATT_R = 2'b01,
    REG_FMT   = 2'b10,
    REG_CLK   = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] out_len;
    logic [1:0] in_len;
    logic       deemph;
    logic       mute_n;
  } fmt_reg_t;

  typedef struct packed {
    logic [1:0] rate;
    logic       clk_half;
    logic       slow;
    logic       common;
    logic       lr_inv;
    logic       i2s;
  } clk_reg_t;

  localparam fmt_reg_t FMT_RESET = '{out_len: 2'b00, in_len: 2'b00,
                                     deemph: 1'b0, mute_n: 1'b1};
  localparam clk_reg_t CLK_RESET = '0;
  localparam logic [ATT_W-1:0] ATT_RESET = '1;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_in,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], async_in[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign level[g] = chain[STAGES-1];
    assign rise[g]  = chain[STAGES-1] & ~last;
  end
endmodule

// File: rtl/sctl_deser.sv
module sctl_deser
  import sctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_rise,
  input  logic                 latch_rise,
  input  logic                 data_lvl,
  output logic                 wr_valid,
  output logic [WORD_BITS-1:0] wr_word,
  output logic [CNT_W-1:0]     bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_BITS + 1);

  logic [WORD_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      wr_valid <= 1'b0;
      wr_word  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (latch_rise) begin
        bit_cnt <= '0;
        if (bit_cnt == CNT_FULL) begin
          wr_valid <= 1'b1;
          wr_word  <= shreg;
        end
      end else if (shift_rise) begin
        shreg <= {shreg[WORD_BITS-2:0], data_lvl};
        if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sctl_bank.sv
module sctl_bank
  import sctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [WORD_BITS-1:0] wr_word,
  output logic [ATT_W-1:0]     app_left,
  output logic [ATT_W-1:0]     app_right,
  output fmt_reg_t             fmt_q,
  output clk_reg_t             clk_q
);
  logic [ATT_W-1:0] store_left, store_right;
  reg_sel_e         sel;
  logic             load;
  logic [ATT_W-1:0] code;
  fmt_reg_t         fmt_d;
  clk_reg_t         clk_d;

  assign sel  = reg_sel_e'(wr_word[ADDR_HI:ADDR_LO]);
  assign load = wr_word[LOAD_BIT];
  assign code = wr_word[ATT_W-1:0];

  always_comb begin
    fmt_d.out_len = wr_word[6:5];
    fmt_d.in_len  = wr_word[4:3];
    fmt_d.deemph  = wr_word[1];
    fmt_d.mute_n  = wr_word[0];
    clk_d.rate     = wr_word[6:5];
    clk_d.clk_half = wr_word[4];
    clk_d.slow     = wr_word[3];
    clk_d.common   = wr_word[2];
    clk_d.lr_inv   = wr_word[1];
    clk_d.i2s      = wr_word[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_left  <= ATT_RESET;
      store_right <= ATT_RESET;
      app_left    <= ATT_RESET;
      app_right   <= ATT_RESET;
      fmt_q       <= FMT_RESET;
      clk_q       <= CLK_RESET;
    end else if (wr_valid) begin
      unique case (sel)
        REG_ATT_L: begin
          store_left <= code;
          if (load) begin
            app_left  <= code;
            app_right <= clk_q.common ? code : store_right;
          end
        end
        REG_ATT_R: begin
          store_right <= code;
          if (load) begin
            app_left  <= store_left;
            app_right <= clk_q.common ? store_left : code;
          end
        end
        REG_FMT: fmt_q <= fmt_d;
        REG_CLK: clk_q <= clk_d;
      endcase
    end
  end
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cp_latch,
  input  logic             cp_clk,
  input  logic             cp_data,
  output logic [ATT_W-1:0] att_left,
  output logic [ATT_W-1:0] att_right,
  output logic             mute_on,
  output logic             deemph_en,
  output logic [1:0]       deemph_rate,
  output logic             in_i2s,
  output logic [1:0]       in_len,
  output logic [1:0]       out_len,
  output logic             left_high,
  output logic             slow_rolloff,
  output logic             clkout_half
);
  logic [2:0]           lvl, rise;
  logic                 wr_valid;
  logic [WORD_BITS-1:0] wr_word;
  logic [CNT_W-1:0]     bit_cnt;
  fmt_reg_t             fmt_q;
  clk_reg_t             clk_q;
  logic                 latch_rise;

  sctl_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({cp_latch, cp_clk, cp_data}),
    .level(lvl), .rise(rise)
  );

  assign latch_rise = rise[2];

  sctl_deser u_deser (
    .clk(clk), .rst_n(rst_n),
    .shift_rise(rise[1]), .latch_rise(latch_rise), .data_lvl(lvl[0]),
    .wr_valid(wr_valid), .wr_word(wr_word), .bit_cnt(bit_cnt)
  );

  sctl_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_word(wr_word),
    .app_left(att_left), .app_right(att_right),
    .fmt_q(fmt_q), .clk_q(clk_q)
  );

  assign mute_on      = ~fmt_q.mute_n;
  assign deemph_en    = fmt_q.deemph;
  assign in_len       = fmt_q.in_len;
  assign out_len      = fmt_q.out_len;
  assign deemph_rate  = clk_q.rate;
  assign clkout_half  = clk_q.clk_half;
  assign slow_rolloff = clk_q.slow;
  assign left_high    = ~clk_q.lr_inv;
  assign in_i2s       = clk_q.i2s;
endmodule

// File: rtl/sctl_chk.sv
module sctl_chk
  import sctl_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 latch_rise,
  input logic [CNT_W-1:0]     bit_cnt,
  input logic                 wr_valid,
  input logic [WORD_BITS-1:0] wr_word,
  input logic [ATT_W-1:0]     att_left,
  input logic [ATT_W-1:0]     att_right,
  input logic                 mute_on,
  input logic                 deemph_en,
  input logic                 left_high
);
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_BITS + 1));

  // R3
  short_long_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && bit_cnt != CNT_W'(WORD_BITS)) |=> !wr_valid);

  // R2
  full_word_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && bit_cnt == CNT_W'(WORD_BITS)) |=> wr_valid);

  // R6
  att_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid || !wr_word[LOAD_BIT]) |=> ($stable(att_left) && $stable(att_right)));

  // R4
  fmt_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word[ADDR_HI:ADDR_LO] == 2'b10) |=>
      (deemph_en == $past(wr_word[1]) && mute_on == !$past(wr_word[0])));

  // R5
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word[ADDR_HI:ADDR_LO] == 2'b11) |=> left_high == !$past(wr_word[1]));
endmodule

bind sctl_regfile sctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .latch_rise(latch_rise), .bit_cnt(bit_cnt),
  .wr_valid(wr_valid), .wr_word(wr_word), .att_left(att_left),
  .att_right(att_right), .mute_on(mute_on), .deemph_en(deemph_en),
  .left_high(left_high)
);

// File: tb/test_sctl_regfile.sv
module test_sctl_regfile;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cp_latch = 1'b1, cp_clk = 1'b1, cp_data = 1'b0;
  logic [7:0] att_left, att_right;
  logic mute_on, deemph_en, in_i2s, left_high, slow_rolloff, clkout_half;
  logic [1:0] deemph_rate, in_len, out_len;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [27:0] exp_q[$];
  string       tag_q[$];
  event        word_sent;

  logic [7:0] m_sl = 8'hFF, m_sr = 8'hFF, m_al = 8'hFF, m_ar = 8'hFF;
  logic [1:0] m_ol = 0, m_il = 0, m_rate = 0;
  logic m_dem = 0, m_mutn = 1, m_ckh = 0, m_slow = 0, m_atc = 0, m_lrp = 0, m_i2s = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sctl_regfile i_sctl_regfile (
    .clk(clk), .rst_n(rst_n), .cp_latch(cp_latch), .cp_clk(cp_clk), .cp_data(cp_data),
    .att_left(att_left), .att_right(att_right), .mute_on(mute_on), .deemph_en(deemph_en),
    .deemph_rate(deemph_rate), .in_i2s(in_i2s), .in_len(in_len), .out_len(out_len),
    .left_high(left_high), .slow_rolloff(slow_rolloff), .clkout_half(clkout_half)
  );

  function automatic logic [27:0] model_vec();
    return {m_al, m_ar, ~m_mutn, m_dem, m_rate, m_i2s, m_il, m_ol, ~m_lrp, m_slow, m_ckh};
  endfunction

  function automatic logic [27:0] dut_vec();
    return {att_left, att_right, mute_on, deemph_en, deemph_rate, in_i2s, in_len, out_len,
            left_high, slow_rolloff, clkout_half};
  endfunction

  // Expected effect of one accepted word, from R2 and R4..R9
  task automatic model_apply(input logic [15:0] w);
    case (w[10:9])
      2'b00: begin
        m_sl = w[7:0];
        if (w[8]) begin m_al = m_sl; m_ar = m_atc ? m_sl : m_sr; end
      end
      2'b01: begin
        m_sr = w[7:0];
        if (w[8]) begin m_al = m_sl; m_ar = m_atc ? m_sl : m_sr; end
      end
      2'b10: begin m_ol = w[6:5]; m_il = w[4:3]; m_dem = w[1]; m_mutn = w[0]; end
      default: begin
        m_rate = w[6:5]; m_ckh = w[4]; m_slow = w[3]; m_atc = w[2]; m_lrp = w[1]; m_i2s = w[0];
      end
    endcase
  endtask

  task automatic send(input logic [31:0] w, input int n, input string tag);
    cp_latch = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      cp_data = w[i];
      cp_clk  = 1'b0;
      repeat (2) @(negedge clk);
      cp_clk  = 1'b1;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    if (n == 16) model_apply(w[15:0]);
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
    cp_latch = 1'b1;
    -> word_sent;
    repeat (10) @(negedge clk);
  endtask

  // Monitor: R10 latency window of five system clocks after the latch edge
  initial begin
    forever begin
      @(word_sent);
      repeat (5) @(negedge clk);
      begin
        logic [27:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (dut_vec() !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, dut_vec(), e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    checks++;
    if (dut_vec() !== model_vec()) begin
      errors++;
      $display("FAIL R1 reset actual %h expected %h", dut_vec(), model_vec());
    end
    send(32'h0472, 16, "R4 R10 format word");
    send(32'h067B, 16, "R5 clock word");
    send(32'h0040, 16, "R6 left store no load");
    send(32'h0320, 16, "R7 right load independent");
    send(32'h067F, 16, "R8 common on without load");
    send(32'h0110, 16, "R7 left load common");
    send(32'h0401, 15, "R3 short word dropped");
    send(32'h00401, 17, "R3 long word dropped");
    send(32'h0401, 16, "R3 count restarts R2");
    send(32'hFD87, 16, "R9 reserved bits");
    send(32'h0277, 16, "R6 right store no load");
    send(32'h0355, 16, "R7 right load common");
    send(32'h067B, 16, "R8 common off without load");
    send(32'h0180, 16, "R7 left load independent");
    send(32'h0100, 16, "R7 left load zero code");
    send(32'h0060, 16, "R6 left store hold");
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule